// File: doc/BRIEF.md
# Credit-Based Proxy Thread Mailbox

This block is a bank of one-way message threads reached over a simple request/acknowledge register port. Every thread exposes a status word, a window of fifteen 32-bit data words and, in a separate control space, a control word whose top bit sets its direction. On a transmit thread, software writes the message words and then writes the final word. That final write hands the whole message to the remote side and uses up one credit. The remote side gives credits back through a per-thread pulse input. On a receive thread, messages arriving from the remote side queue in a small FIFO. Software reads the head message word by word, and reading the final word retires it.

Status reports credits left on a transmit thread and messages waiting on a receive thread. An illegal access sets a sticky fault bit and does nothing else. Each receive thread raises a level interrupt while it holds work and is fault-free.

Register accesses are sequenced by a three-state machine. ST_IDLE waits for a request and captures it, then moves to ST_EXEC. ST_EXEC decodes the address and applies the side effects (stage, send, pop, fault set or clear, direction write), registers the read data and moves to ST_DONE. ST_DONE raises the acknowledge for one cycle and returns to ST_IDLE.

Top module: `mbx_proxy_top`

## Requirements
- R1: After reset every thread is a transmit thread with zero credits, an empty FIFO and no fault. bus_ack, tx_valid and rx_irq are low.
- R2: A request held high in ST_IDLE is acknowledged exactly two cycles after it is captured. bus_ack is high for exactly one cycle, and bus_rdata is valid in that cycle.
- R3: The address decode works as follows. With bus_ctl=0, the status word of thread t is at t*0x1000 and data word k (0 to 14) is at t*0x1000+4+4k. With bus_ctl=1, the control word of thread t is at 0x1000+t*0x1000, and its bit 31 is the direction (1 receive, 0 transmit). An unmapped address reads 0 and a write to it changes nothing.
- R4: Status bits 7:0 of a transmit thread hold its credits. Each credit_ret[t] pulse adds one credit, saturating at CREDIT_MAX (default 4).
- R5: A write to word 14 of a transmit thread that has credits sends a message and removes one credit. In the acknowledge cycle, tx_valid pulses with tx_thread and tx_data. tx_data carries the last values written to words 0..13, plus the word-14 write value, with word k in bits 32k+31:32k.
- R6: A word-14 write on a transmit thread with zero credits sets the fault bit (status bit 31). It sends nothing and leaves the credits at zero.
- R7: A msg_in_valid pulse pushes msg_in_data into the FIFO of thread msg_in_thread, which holds RX_DEPTH (default 2) messages. A push into a full FIFO is dropped. Status bits 7:0 of a receive thread hold the message count. Reading word k returns word k of the head message, and reading word 14 retires the head.
- R8: On a receive thread, two accesses set the fault bit and have no other effect. A data write leaves the FIFO unchanged. A data read while empty returns 0.
- R9: The fault bit is sticky. A status write with bit 31 set clears it, and a status write with bit 31 clear leaves it set.
- R10: rx_irq[t] is high exactly while thread t is a receive thread with a nonzero count and no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, held until bus_ack |
| bus_we | input | 1 | 1 write, 0 read |
| bus_ctl | input | 1 | 1 selects the control space |
| bus_addr | input | 12+clog2(NT+1) | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | One-cycle access completion |
| credit_ret | input | NT | Per-thread credit return pulse |
| msg_in_valid | input | 1 | Incoming message strobe |
| msg_in_thread | input | clog2(NT) | Target thread of the incoming message |
| msg_in_data | input | 480 | Incoming message, word k at bits 32k+31:32k |
| tx_valid | output | 1 | Outgoing message strobe |
| tx_thread | output | clog2(NT) | Source thread of the outgoing message |
| tx_data | output | 480 | Outgoing message, word k at bits 32k+31:32k |
| rx_irq | output | NT | Per-thread receive interrupt |

## Verification
The hardest state to reach is a receive thread that holds a message while its fault is set. In that state the interrupt must be masked, the illegal write must leave the message intact, and clearing the fault must bring the interrupt straight back. The bench gets there by pushing a message through msg_in_valid and then writing a data word of that receive thread. It checks status and rx_irq, clears the fault, and finally reads the head message to prove it survived. Credit saturation is reached by returning one credit more than CREDIT_MAX. FIFO overflow is reached by pushing one message more than RX_DEPTH before any read.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int DW        = 32;
    localparam int MSG_WORDS = 15;
    localparam int MSG_BITS  = DW * MSG_WORDS;
    localparam int STG_BITS  = DW * (MSG_WORDS - 1);
    localparam int CNT_W     = 8;
    localparam int WORD_W    = $clog2(MSG_WORDS);
    localparam int PAGE_LSB  = 12;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXEC,
        ST_DONE
    } acc_state_t;
endpackage

// File: rtl/mbx_credit.sv
module mbx_credit #(
    parameter int CREDIT_MAX = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    inc,
    input  logic                    dec,
    output logic [mbx_pkg::CNT_W-1:0] count
);
    import mbx_pkg::*;
    localparam logic [CNT_W-1:0] CAP = CNT_W'(CREDIT_MAX);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   if (count < CAP) count <= count + 1'b1;
                2'b01:   if (count != '0) count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/mbx_rx_fifo.sv
module mbx_rx_fifo #(
    parameter int DEPTH = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [mbx_pkg::MSG_BITS-1:0] push_data,
    input  logic                       pop,
    output logic [mbx_pkg::MSG_BITS-1:0] head,
    output logic [mbx_pkg::CNT_W-1:0]    count
);
    import mbx_pkg::*;
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    logic [MSG_BITS-1:0] mem [DEPTH];
    logic [PTR_W-1:0]    wp, rp;
    logic                push_ok, pop_ok;

    assign push_ok = push && (count != CNT_W'(DEPTH));
    assign pop_ok  = pop && (count != '0);
    assign head    = mem[rp];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push_ok) wp <= (wp == PTR_LAST) ? '0 : wp + 1'b1;
            if (pop_ok)  rp <= (rp == PTR_LAST) ? '0 : rp + 1'b1;
            unique case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/mbx_proxy_top.sv
module mbx_proxy_top #(
    parameter int NT         = 4,
    parameter int RX_DEPTH   = 2,
    parameter int CREDIT_MAX = 4,
    localparam int TH_W      = (NT > 1) ? $clog2(NT) : 1,
    localparam int TID_W     = $clog2(NT + 1),
    localparam int ADDR_W    = mbx_pkg::PAGE_LSB + TID_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         bus_req,
    input  logic                         bus_we,
    input  logic                         bus_ctl,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic [31:0]                  bus_wdata,
    output logic [31:0]                  bus_rdata,
    output logic                         bus_ack,
    input  logic [NT-1:0]                credit_ret,
    input  logic                         msg_in_valid,
    input  logic [TH_W-1:0]              msg_in_thread,
    input  logic [mbx_pkg::MSG_BITS-1:0] msg_in_data,
    output logic                         tx_valid,
    output logic [TH_W-1:0]              tx_thread,
    output logic [mbx_pkg::MSG_BITS-1:0] tx_data,
    output logic [NT-1:0]                rx_irq
);
    import mbx_pkg::*;
    localparam logic [WORD_W-1:0] LAST = WORD_W'(MSG_WORDS - 1);

    acc_state_t state, nstate;
    logic                 exec;
    logic                 q_we, q_ctl;
    logic [ADDR_W-1:0]    q_addr;
    logic [DW-1:0]        q_wdata;

    logic [NT-1:0]            dir_rx, err;
    logic [NT-1:0][CNT_W-1:0] cred, rcnt;
    logic [MSG_BITS-1:0]      head  [NT];
    logic [STG_BITS-1:0]      stage [NT];

    // Address decode of the captured request
    logic [TID_W-1:0]  page;
    logic [11:0]       off;
    logic [9:0]        widx;
    logic [TH_W-1:0]   th;
    logic [WORD_W-1:0] dword;
    logic hit_status, hit_data, hit_ctrl;

    assign page  = q_addr[ADDR_W-1:PAGE_LSB];
    assign off   = q_addr[11:0];
    assign widx  = off[11:2];
    assign th    = q_ctl ? TH_W'(page - 1'b1) : TH_W'(page);
    assign dword = WORD_W'(widx - 10'd1);

    assign hit_status = !q_ctl && (int'(page) < NT) && (off == 12'd0);
    assign hit_data   = !q_ctl && (int'(page) < NT) && (off[1:0] == 2'b00)
                        && (widx != 10'd0) && (widx <= 10'(MSG_WORDS));
    assign hit_ctrl   = q_ctl && (page != '0) && (int'(page) <= NT) && (off == 12'd0);

    // Effects applied in ST_EXEC
    logic is_rx, do_send, do_stage, do_pop, set_err, clr_err, ctrl_wr;
    logic [DW-1:0] rd_val;

    assign is_rx    = dir_rx[th];
    assign do_stage = exec && hit_data && q_we && !is_rx && (dword != LAST);
    assign do_send  = exec && hit_data && q_we && !is_rx && (dword == LAST) && (cred[th] != '0);
    assign do_pop   = exec && hit_data && !q_we && is_rx && (dword == LAST) && (rcnt[th] != '0);
    assign set_err  = exec && hit_data &&
                      ((q_we && is_rx) ||
                       (q_we && !is_rx && (dword == LAST) && (cred[th] == '0)) ||
                       (!q_we && is_rx && (rcnt[th] == '0)));
    assign clr_err  = exec && hit_status && q_we && q_wdata[31];
    assign ctrl_wr  = exec && hit_ctrl && q_we;

    always_comb begin
        rd_val = '0;
        if (hit_status)
            rd_val = {err[th], 23'd0, is_rx ? rcnt[th] : cred[th]};
        else if (hit_ctrl)
            rd_val = {dir_rx[th], 31'd0};
        else if (hit_data && is_rx && (rcnt[th] != '0))
            rd_val = head[th][dword*DW +: DW];
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nstate;
    end

    // Next-state logic
    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: if (bus_req) nstate = ST_EXEC;
            ST_EXEC: nstate = ST_DONE;
            ST_DONE: nstate = ST_IDLE;
            default: nstate = ST_IDLE;
        endcase
    end

    // State-decoded outputs
    always_comb begin
        exec    = 1'b0;
        bus_ack = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_EXEC: exec    = 1'b1;
            ST_DONE: bus_ack = 1'b1;
            default: ;
        endcase
    end

    // Request capture, read data and outgoing message
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_we      <= 1'b0;
            q_ctl     <= 1'b0;
            q_addr    <= '0;
            q_wdata   <= '0;
            bus_rdata <= '0;
            tx_valid  <= 1'b0;
            tx_thread <= '0;
            tx_data   <= '0;
        end else begin
            if (state == ST_IDLE && bus_req) begin
                q_we    <= bus_we;
                q_ctl   <= bus_ctl;
                q_addr  <= bus_addr;
                q_wdata <= bus_wdata;
            end
            if (exec) bus_rdata <= rd_val;
            tx_valid <= do_send;
            if (do_send) begin
                tx_thread <= th;
                tx_data   <= {q_wdata, stage[th]};
            end
        end
    end

    // Per-thread state
    for (genvar g = 0; g < NT; g++) begin : g_thr
        logic sel;
        assign sel = (th == TH_W'(g));

        mbx_credit #(.CREDIT_MAX(CREDIT_MAX)) u_credit (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (credit_ret[g]),
            .dec   (do_send && sel),
            .count (cred[g])
        );

        mbx_rx_fifo #(.DEPTH(RX_DEPTH)) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (msg_in_valid && (msg_in_thread == TH_W'(g))),
            .push_data (msg_in_data),
            .pop       (do_pop && sel),
            .head      (head[g]),
            .count     (rcnt[g])
        );

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                err[g]    <= 1'b0;
                dir_rx[g] <= 1'b0;
            end else begin
                if (set_err && sel)      err[g] <= 1'b1;
                else if (clr_err && sel) err[g] <= 1'b0;
                if (ctrl_wr && sel)      dir_rx[g] <= q_wdata[31];
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n)                stage[g] <= '0;
            else if (do_stage && sel)  stage[g][dword*DW +: DW] <= q_wdata;
        end

        assign rx_irq[g] = dir_rx[g] && (rcnt[g] != '0) && !err[g];
    end
endmodule

// File: rtl/mbx_proxy_chk.sv
module mbx_proxy_chk #(
    parameter int NT         = 4,
    parameter int RX_DEPTH   = 2,
    parameter int CREDIT_MAX = 4,
    parameter int TH_W       = 2
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              bus_ack,
    input logic                              in_exec,
    input logic                              tx_valid,
    input logic [TH_W-1:0]                   tx_thread,
    input logic [NT-1:0][mbx_pkg::CNT_W-1:0] cred,
    input logic [NT-1:0][mbx_pkg::CNT_W-1:0] rcnt,
    input logic [NT-1:0]                     err
);
    import mbx_pkg::*;

    p_ack_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    for (genvar g = 0; g < NT; g++) begin : g_chk
        p_credit_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
            cred[g] <= CNT_W'(CREDIT_MAX));

        p_send_needs_credit_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (tx_valid && tx_thread == TH_W'(g)) |-> ($past(cred[g]) != '0));

        p_fifo_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
            rcnt[g] <= CNT_W'(RX_DEPTH));

        p_err_from_access_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(err[g]) |-> $past(in_exec));
    end
endmodule

bind mbx_proxy_top mbx_proxy_chk #(
    .NT(NT), .RX_DEPTH(RX_DEPTH), .CREDIT_MAX(CREDIT_MAX), .TH_W(TH_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_ack   (bus_ack),
    .in_exec   (exec),
    .tx_valid  (tx_valid),
    .tx_thread (tx_thread),
    .cred      (cred),
    .rcnt      (rcnt),
    .err       (err)
);

// File: tb/mbx_proxy_top_bench.sv
module mbx_proxy_top_bench;
    import mbx_pkg::*;
    localparam int NT     = 4;
    localparam int TH_W   = 2;
    localparam int ADDR_W = 15;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_req = 1'b0, bus_we = 1'b0, bus_ctl = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0, bus_rdata;
    logic              bus_ack;
    logic [NT-1:0]     credit_ret = '0;
    logic              msg_in_valid = 1'b0;
    logic [TH_W-1:0]   msg_in_thread = '0;
    logic [MSG_BITS-1:0] msg_in_data = '0;
    logic              tx_valid;
    logic [TH_W-1:0]   tx_thread;
    logic [MSG_BITS-1:0] tx_data;
    logic [NT-1:0]     rx_irq;

    int checks = 0, failures = 0;
    bit done = 0;
    logic [31:0] rd;
    logic        cap_tx_valid;
    logic [TH_W-1:0] cap_tx_thread;
    logic [MSG_BITS-1:0] cap_tx_data;
    int          ack_wait;

    always #10 clk = ~clk;

    mbx_proxy_top u_mbx_proxy_top (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we), .bus_ctl(bus_ctl),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .credit_ret(credit_ret), .msg_in_valid(msg_in_valid), .msg_in_thread(msg_in_thread),
        .msg_in_data(msg_in_data), .tx_valid(tx_valid), .tx_thread(tx_thread),
        .tx_data(tx_data), .rx_irq(rx_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] a_stat(input int t);
        return ADDR_W'(t * 4096);
    endfunction
    function automatic logic [ADDR_W-1:0] a_word(input int t, input int k);
        return ADDR_W'(t * 4096 + 4 + 4 * k);
    endfunction
    function automatic logic [ADDR_W-1:0] a_ctrl(input int t);
        return ADDR_W'(4096 + t * 4096);
    endfunction

    task automatic access(input logic ctl, input logic we, input logic [ADDR_W-1:0] a,
                          input logic [31:0] wd);
        @(negedge clk);
        bus_req = 1'b1; bus_ctl = ctl; bus_we = we; bus_addr = a; bus_wdata = wd;
        ack_wait = 0;
        @(negedge clk);
        while (!bus_ack && ack_wait < 10) begin
            ack_wait++;
            @(negedge clk);
        end
        rd = bus_rdata;
        cap_tx_valid = tx_valid; cap_tx_thread = tx_thread; cap_tx_data = tx_data;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic push_msg(input int t, input logic [31:0] base);
        @(negedge clk);
        msg_in_valid = 1'b1; msg_in_thread = TH_W'(t);
        for (int k = 0; k < MSG_WORDS; k++) msg_in_data[k*32 +: 32] = base + 32'(k);
        @(negedge clk);
        msg_in_valid = 1'b0;
    endtask

    task automatic give_credit(input int t);
        @(negedge clk);
        credit_ret[t] = 1'b1;
        @(negedge clk);
        credit_ret[t] = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 ack low", {31'd0, bus_ack}, 0);
        chk("R1 tx_valid low", {31'd0, tx_valid}, 0);
        chk("R1 irq low", {28'd0, rx_irq}, 0);
        access(1'b0, 1'b0, a_stat(0), 0);
        chk("R1 status t0", rd, 0);
        access(1'b1, 1'b0, a_ctrl(3), 0);
        chk("R1 ctrl t3 dir", rd, 0);
    endtask

    task automatic t_timing;
        @(negedge clk);
        bus_req = 1'b1; bus_ctl = 1'b0; bus_we = 1'b0; bus_addr = a_stat(1);
        @(negedge clk);
        chk("R2 no ack after capture", {31'd0, bus_ack}, 0);
        @(negedge clk);
        chk("R2 ack second cycle", {31'd0, bus_ack}, 1);
        bus_req = 1'b0;
        @(negedge clk);
        chk("R2 ack one cycle", {31'd0, bus_ack}, 0);
    endtask

    task automatic t_decode;
        access(1'b1, 1'b1, a_ctrl(2), 32'h8000_0000);
        access(1'b1, 1'b0, a_ctrl(2), 0);
        chk("R3 ctrl dir readback", rd, 32'h8000_0000);
        access(1'b1, 1'b1, a_ctrl(2), 32'h0);
        access(1'b1, 1'b0, a_ctrl(2), 0);
        chk("R3 ctrl dir back to tx", rd, 0);
        access(1'b1, 1'b0, ADDR_W'(0), 0);
        chk("R3 ctrl space page0 unmapped", rd, 0);
        access(1'b0, 1'b1, ADDR_W'(16'h4000), 32'hFFFF_FFFF);
        access(1'b0, 1'b0, ADDR_W'(16'h4000), 0);
        chk("R3 thread beyond NT unmapped", rd, 0);
        access(1'b0, 1'b1, ADDR_W'(16'h0040), 32'h1234);
        access(1'b0, 1'b0, a_stat(0), 0);
        chk("R3 word past window no effect", rd, 0);
    endtask

    task automatic t_credit;
        for (int i = 0; i < 5; i++) give_credit(0);
        access(1'b0, 1'b0, a_stat(0), 0);
        chk("R4 credits saturate at 4", rd, 32'd4);
        access(1'b0, 1'b0, a_stat(1), 0);
        chk("R4 other thread untouched", rd, 0);
    endtask

    task automatic t_zero_credit;
        access(1'b0, 1'b1, a_word(3, 14), 32'hDEAD);
        chk("R6 no send at zero credit", {31'd0, cap_tx_valid}, 0);
        access(1'b0, 1'b0, a_stat(3), 0);
        chk("R6 fault set credits zero", rd, 32'h8000_0000);
    endtask

    task automatic t_send;
        for (int k = 0; k < 14; k++) access(1'b0, 1'b1, a_word(0, k), 32'hA0 + 32'(k));
        chk("R5 no send on staging", {31'd0, cap_tx_valid}, 0);
        access(1'b0, 1'b1, a_word(0, 14), 32'h5555_0000);
        chk("R5 tx_valid", {31'd0, cap_tx_valid}, 1);
        chk("R5 tx_thread", {30'd0, cap_tx_thread}, 0);
        chk("R5 word0", cap_tx_data[31:0], 32'hA0);
        chk("R5 word13", cap_tx_data[13*32 +: 32], 32'hAD);
        chk("R5 word14", cap_tx_data[14*32 +: 32], 32'h5555_0000);
        @(negedge clk);
        chk("R5 tx_valid one cycle", {31'd0, tx_valid}, 0);
        access(1'b0, 1'b0, a_stat(0), 0);
        chk("R5 credit consumed", rd, 32'd3);
    endtask

    task automatic t_receive;
        access(1'b1, 1'b1, a_ctrl(1), 32'h8000_0000);
        push_msg(1, 32'h100);
        chk("R10 irq on arrival", {28'd0, rx_irq}, 4'b0010);
        push_msg(1, 32'h200);
        push_msg(1, 32'h300);
        access(1'b0, 1'b0, a_stat(1), 0);
        chk("R7 count capped at depth", rd, 32'd2);
        access(1'b0, 1'b0, a_word(1, 3), 0);
        chk("R7 head word3", rd, 32'h103);
        access(1'b0, 1'b0, a_word(1, 14), 0);
        chk("R7 head word14", rd, 32'h10E);
        access(1'b0, 1'b0, a_word(1, 0), 0);
        chk("R7 second message", rd, 32'h200);
        access(1'b0, 1'b0, a_word(1, 14), 0);
        access(1'b0, 1'b0, a_stat(1), 0);
        chk("R7 empty after pops", rd, 0);
        chk("R10 irq drops when empty", {28'd0, rx_irq}, 0);
    endtask

    task automatic t_rx_errors;
        access(1'b0, 1'b0, a_word(1, 0), 0);
        chk("R8 empty read data", rd, 0);
        access(1'b0, 1'b0, a_stat(1), 0);
        chk("R8 empty read fault", rd, 32'h8000_0000);
        access(1'b0, 1'b1, a_stat(1), 32'h0000_0001);
        access(1'b0, 1'b0, a_stat(1), 0);
        chk("R9 write without bit31 keeps fault", rd, 32'h8000_0000);
        access(1'b0, 1'b1, a_stat(1), 32'h8000_0000);
        access(1'b0, 1'b0, a_stat(1), 0);
        chk("R9 clear fault", rd, 0);
        push_msg(1, 32'h400);
        access(1'b0, 1'b1, a_word(1, 14), 32'hBEEF);
        access(1'b0, 1'b0, a_stat(1), 0);
        chk("R8 data write on rx faults, count kept", rd, 32'h8000_0001);
        chk("R10 irq masked by fault", {28'd0, rx_irq}, 0);
        access(1'b0, 1'b1, a_stat(1), 32'h8000_0000);
        chk("R10 irq back after clear", {28'd0, rx_irq}, 4'b0010);
        access(1'b0, 1'b0, a_word(1, 14), 0);
        chk("R8 message unchanged by write", rd, 32'h40E);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_timing();
        t_decode();
        t_credit();
        t_zero_credit();
        t_send();
        t_receive();
        t_rx_errors();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog R2 actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule